// File: doc/BRIEF.md
# Home-Node Coherence Directory

This block is the home directory for a small multiprocessor whose memory is spread over several nodes. For every memory block it owns, it keeps a sharing state and a per-node presence mask. Cache controllers send it one request at a time: read miss, write miss or write-back. Each request carries a block index and the node that sent it. The directory answers with message commands:

- a data reply to the requester,
- a bitmask of nodes that must invalidate their copy,
- a fetch command that pulls a dirty copy back from its owner.

Requests are taken one at a time, so the directory decides the order of competing writes to a block. While it waits for an owner to answer a fetch, it takes no new request. The interconnect, the memory array and the cache controllers are outside the block. Only the message commands and the directory state are modelled.

A request is accepted on a cycle where `req_valid` and `req_ready` are both high. Its messages appear as one-cycle pulses two clock edges after acceptance. When the request needs an owner fetch, the data reply follows one edge after `own_ack` is sampled high.

Top module: `coh_directory`

## Requirements
- R1: After reset every block is uncached with an empty presence mask, `req_ready` is high and no message pulse is active.
- R2: A read miss (`req_kind` = 2'b00) on an uncached block sends a data reply to the requester and no fetch. The block becomes shared with only the requester present.
- R3: A write miss (`req_kind` = 2'b01) on an uncached block sends a data reply with no invalidate. The block becomes exclusive, owned by the requester.
- R4: A read miss on a shared block sends a data reply with no invalidate and no fetch, and adds the requester to the presence mask.
- R5: A write miss on a shared block sends a data reply and an invalidate mask holding every present node except the requester. The requester becomes the exclusive owner.
- R6: A read miss on an exclusive block owned by another node first issues a fetch to the owner. After the acknowledge it sends the data reply, and the block becomes shared with the old owner and the requester present.
- R7: A write-back (`req_kind` = 2'b10) from the owner of an exclusive block emits no message and returns the block to uncached with an empty mask.
- R8: A write miss on an exclusive block owned by another node fetches from the owner. After the acknowledge it replies with data and no invalidate. The block stays exclusive with the requester as owner.
- R9: From the fetch pulse until `own_ack` is sampled, `req_ready` is low and no data reply is sent. The data reply appears one edge after the acknowledge.
- R10: An invalidate mask (bit n = node n) never contains the requesting node.
- R11: A write-back from a node that is not the exclusive owner, or the unused code 2'b11, emits nothing and leaves the entry unchanged.
- R12: A request changes only the entry named by its block index. `msg_block` carries that index with every message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Directory can accept a request |
| req_kind | input | 2 | 00 read miss, 01 write miss, 10 write-back, 11 no-op |
| req_block | input | 4 | Block index |
| req_node | input | 3 | Requesting node |
| own_ack | input | 1 | Owner has returned the fetched data |
| data_valid | output | 1 | Data reply pulse |
| data_node | output | 3 | Destination of the data reply |
| inv_valid | output | 1 | Invalidate pulse |
| inv_mask | output | 8 | Nodes to invalidate |
| fetch_valid | output | 1 | Fetch-from-owner pulse |
| fetch_node | output | 3 | Owner to fetch from |
| msg_block | output | 4 | Block index of the current message |

## Verification
A corrupt presence mask or state cannot be read directly. It shows up the next time the same block is touched:

- a missing or extra sharer appears in the invalidate mask of a later write miss;
- a wrong owner appears as the fetch target of a later read;
- a wrong state appears as a fetch where none was due, or a missing one.

Each scenario therefore follows a state-changing request with a probe request on the same block, and checks the probe's pulses two edges after acceptance. A mistake in the wait handshake shows at once as `req_ready` high, or a data reply, before the acknowledge.

// File: rtl/coh_dir_pkg.sv
package coh_dir_pkg;
    parameter int NODES  = 8;
    parameter int BLOCKS = 16;
    localparam int NODE_W = $clog2(NODES);
    localparam int BLK_W  = $clog2(BLOCKS);

    typedef enum logic [1:0] {
        ST_UNCACHED = 2'd0,
        ST_SHARED   = 2'd1,
        ST_EXCL     = 2'd2
    } dir_state_e;

    typedef enum logic [1:0] {
        RK_READ  = 2'd0,
        RK_WRITE = 2'd1,
        RK_WBACK = 2'd2,
        RK_NONE  = 2'd3
    } req_kind_e;

    typedef struct packed {
        dir_state_e        st;
        logic [NODES-1:0]  present;
    } dir_entry_t;

    typedef struct packed {
        req_kind_e          kind;
        logic [BLK_W-1:0]   blk;
        logic [NODE_W-1:0]  node;
    } dir_req_t;

    typedef struct packed {
        logic               fetch;
        logic               reply;
        logic               update;
        logic [NODE_W-1:0]  fnode;
        logic [NODES-1:0]   inv;
        dir_entry_t         nxt;
    } dir_action_t;

    // lowest set bit of a presence mask; the owner of an exclusive entry
    function automatic logic [NODE_W-1:0] owner_of(input logic [NODES-1:0] m);
        logic [NODE_W-1:0] r;
        r = '0;
        for (int i = NODES - 1; i >= 0; i--) begin
            if (m[i]) r = NODE_W'(i);
        end
        return r;
    endfunction
endpackage

// File: rtl/coh_dir_table.sv
module coh_dir_table
    import coh_dir_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [BLK_W-1:0]  idx,
    output dir_entry_t        rd_entry,
    input  logic              we,
    input  dir_entry_t        wr_entry
);
    dir_entry_t mem [BLOCKS];

    assign rd_entry = mem[idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int b = 0; b < BLOCKS; b++) begin
                mem[b] <= '{st: ST_UNCACHED, present: '0};
            end
        end else if (we) begin
            mem[idx] <= wr_entry;
        end
    end

    AST_EXCL_ONE_OWNER: assert property (@(posedge clk) disable iff (rst)
        (we && wr_entry.st == ST_EXCL) |-> $onehot(wr_entry.present)); // R3
    AST_UNCACHED_EMPTY: assert property (@(posedge clk) disable iff (rst)
        (we && wr_entry.st == ST_UNCACHED) |-> (wr_entry.present == '0)); // R7
endmodule

// File: rtl/coh_dir_policy.sv
module coh_dir_policy
    import coh_dir_pkg::*;
(
    input  dir_req_t     req,
    input  dir_entry_t   cur,
    output dir_action_t  act
);
    logic [NODES-1:0]  req_bit;
    logic              is_owner;
    logic [NODE_W-1:0] own;

    assign req_bit  = NODES'(1) << req.node;
    assign own      = owner_of(cur.present);
    assign is_owner = (cur.st == ST_EXCL) && cur.present[req.node];

    always_comb begin
        act        = '0;
        act.nxt    = cur;
        act.fnode  = own;
        unique case (req.kind)
            RK_READ: begin
                act.reply  = 1'b1;
                act.update = 1'b1;
                unique case (cur.st)
                    ST_UNCACHED: act.nxt = '{st: ST_SHARED, present: req_bit};
                    ST_SHARED:   act.nxt = '{st: ST_SHARED, present: cur.present | req_bit};
                    ST_EXCL: begin
                        if (!is_owner) begin
                            act.fetch = 1'b1;
                            act.nxt   = '{st: ST_SHARED, present: cur.present | req_bit};
                        end
                    end
                    default: act.nxt = cur;
                endcase
            end
            RK_WRITE: begin
                act.reply  = 1'b1;
                act.update = 1'b1;
                act.nxt    = '{st: ST_EXCL, present: req_bit};
                unique case (cur.st)
                    ST_SHARED: act.inv   = cur.present & ~req_bit;
                    ST_EXCL:   act.fetch = !is_owner;
                    default:   act.inv   = '0;
                endcase
            end
            RK_WBACK: begin
                if (is_owner) begin
                    act.update = 1'b1;
                    act.nxt    = '{st: ST_UNCACHED, present: '0};
                end
            end
            default: act.update = 1'b0;
        endcase
    end
endmodule

// File: rtl/coh_directory.sv
module coh_directory
    import coh_dir_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [1:0]         req_kind,
    input  logic [BLK_W-1:0]   req_block,
    input  logic [NODE_W-1:0]  req_node,
    input  logic               own_ack,
    output logic               data_valid,
    output logic [NODE_W-1:0]  data_node,
    output logic               inv_valid,
    output logic [NODES-1:0]   inv_mask,
    output logic               fetch_valid,
    output logic [NODE_W-1:0]  fetch_node,
    output logic [BLK_W-1:0]   msg_block
);
    typedef enum logic [1:0] {PH_IDLE, PH_ACT, PH_WAIT} phase_e;

    phase_e       phase;
    dir_req_t     cur_req;
    dir_entry_t   entry;
    dir_action_t  act;
    logic         tbl_we;

    coh_dir_table u_table (
        .clk      (clk),
        .rst      (rst),
        .idx      (cur_req.blk),
        .rd_entry (entry),
        .we       (tbl_we),
        .wr_entry (act.nxt)
    );

    coh_dir_policy u_policy (
        .req (cur_req),
        .cur (entry),
        .act (act)
    );

    assign req_ready = (phase == PH_IDLE);
    assign tbl_we = ((phase == PH_ACT) && act.update && !act.fetch)
                  || ((phase == PH_WAIT) && own_ack);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase       <= PH_IDLE;
            cur_req     <= '0;
            data_valid  <= 1'b0;
            data_node   <= '0;
            inv_valid   <= 1'b0;
            inv_mask    <= '0;
            fetch_valid <= 1'b0;
            fetch_node  <= '0;
            msg_block   <= '0;
        end else begin
            data_valid  <= 1'b0;
            inv_valid   <= 1'b0;
            inv_mask    <= '0;
            fetch_valid <= 1'b0;
            unique case (phase)
                PH_IDLE: begin
                    if (req_valid) begin
                        cur_req <= '{kind: req_kind_e'(req_kind), blk: req_block, node: req_node};
                        phase   <= PH_ACT;
                    end
                end
                PH_ACT: begin
                    msg_block <= cur_req.blk;
                    if (act.fetch) begin
                        fetch_valid <= 1'b1;
                        fetch_node  <= act.fnode;
                        phase       <= PH_WAIT;
                    end else begin
                        data_valid <= act.reply;
                        data_node  <= cur_req.node;
                        inv_valid  <= |act.inv;
                        inv_mask   <= act.inv;
                        phase      <= PH_IDLE;
                    end
                end
                PH_WAIT: begin
                    if (own_ack) begin
                        data_valid <= 1'b1;
                        data_node  <= cur_req.node;
                        phase      <= PH_IDLE;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    AST_INV_NOT_REQUESTER: assert property (@(posedge clk) disable iff (rst)
        inv_valid |-> (data_valid && !inv_mask[data_node])); // R10
    AST_FETCH_BLOCKS_READY: assert property (@(posedge clk) disable iff (rst)
        fetch_valid |-> (!req_ready && !data_valid)); // R9
    AST_ACK_GIVES_DATA: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_WAIT && own_ack) |=> (data_valid && req_ready)); // R9
    AST_FETCH_OTHER_NODE: assert property (@(posedge clk) disable iff (rst)
        fetch_valid |-> (fetch_node != cur_req.node)); // R6
    AST_NO_REPLY_ON_WBACK: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_ACT && cur_req.kind == RK_WBACK) |=> (!data_valid && !inv_valid && !fetch_valid)); // R7
endmodule

// File: tb/test_coh_directory.sv
`timescale 1ns/1ps
module test_coh_directory;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_valid = 1'b0;
    logic       req_ready;
    logic [1:0] req_kind = 2'b00;
    logic [3:0] req_block = '0;
    logic [2:0] req_node = '0;
    logic       own_ack = 1'b0;
    logic       data_valid, inv_valid, fetch_valid;
    logic [2:0] data_node, fetch_node;
    logic [7:0] inv_mask;
    logic [3:0] msg_block;

    int n_tests = 0;
    int n_fail  = 0;

    logic       c_data, c_inv, c_fetch, c_ready;
    logic [2:0] c_dnode, c_fnode;
    logic [7:0] c_imask;
    logic [3:0] c_blk;

    always #4 clk = ~clk;

    coh_directory i_coh_directory (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_kind(req_kind), .req_block(req_block), .req_node(req_node),
        .own_ack(own_ack), .data_valid(data_valid), .data_node(data_node),
        .inv_valid(inv_valid), .inv_mask(inv_mask), .fetch_valid(fetch_valid),
        .fetch_node(fetch_node), .msg_block(msg_block)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic capture();
        c_data = data_valid; c_dnode = data_node; c_inv = inv_valid;
        c_imask = inv_mask; c_fetch = fetch_valid; c_fnode = fetch_node;
        c_ready = req_ready; c_blk = msg_block;
    endtask

    // drive one request, sample the pulses two edges after acceptance
    task automatic do_req(input logic [1:0] k, input logic [3:0] b, input logic [2:0] n);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_kind = k; req_block = b; req_node = n;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        capture();
    endtask

    task automatic do_ack();
        own_ack = 1'b1;
        @(negedge clk);
        own_ack = 1'b0;
        capture();
    endtask

    task automatic expect_reply(input string req, input logic [2:0] n, input logic [7:0] inv);
        chk(c_data == 1'b1, req, "data_valid", c_data, 1);
        chk(c_dnode == n, req, "data_node", c_dnode, n);
        chk(c_fetch == 1'b0, req, "fetch_valid", c_fetch, 0);
        chk(c_inv == (inv != 0) && c_imask == inv, req, "inv_mask", c_imask, inv);
    endtask

    task automatic expect_fetch(input string req, input logic [2:0] owner);
        chk(c_fetch == 1'b1 && c_fnode == owner, req, "fetch_node", c_fetch ? c_fnode : 8, owner);
        chk(c_data == 1'b0 && c_ready == 1'b0, req, "no data / ready low", {c_data, c_ready}, 0);
    endtask

    task automatic expect_silent(input string req);
        chk(!c_data && !c_inv && !c_fetch, req, "no message", {c_data, c_inv, c_fetch}, 0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(req_ready == 1'b1, "R1", "req_ready", req_ready, 1);
        chk(!data_valid && !inv_valid && !fetch_valid, "R1", "idle pulses",
            {data_valid, inv_valid, fetch_valid}, 0);
        do_req(2'b00, 4'd0, 3'd1);
        expect_reply("R1", 3'd1, 8'h00);
    endtask

    task automatic t_read_uncached();
        do_req(2'b00, 4'd1, 3'd2);
        expect_reply("R2", 3'd2, 8'h00);
        do_req(2'b01, 4'd1, 3'd5);
        expect_reply("R2", 3'd5, 8'h04);
    endtask

    task automatic t_read_shared();
        do_req(2'b00, 4'd2, 3'd1);
        do_req(2'b00, 4'd2, 3'd3);
        expect_reply("R4", 3'd3, 8'h00);
        do_req(2'b01, 4'd2, 3'd6);
        expect_reply("R4", 3'd6, 8'h0A);
    endtask

    task automatic t_write_uncached();
        do_req(2'b01, 4'd3, 3'd4);
        expect_reply("R3", 3'd4, 8'h00);
        do_req(2'b00, 4'd3, 3'd0);
        expect_fetch("R3", 3'd4);
        do_ack();
        expect_reply("R3", 3'd0, 8'h00);
    endtask

    task automatic t_read_excl();
        do_req(2'b01, 4'd4, 3'd2);
        do_req(2'b00, 4'd4, 3'd7);
        expect_fetch("R6", 3'd2);
        repeat (3) @(negedge clk);
        chk(req_ready == 1'b0 && data_valid == 1'b0, "R9", "held while waiting",
            {req_ready, data_valid}, 0);
        do_ack();
        expect_reply("R9", 3'd7, 8'h00);
        do_req(2'b01, 4'd4, 3'd1);
        expect_reply("R6", 3'd1, 8'h84);
    endtask

    task automatic t_write_shared();
        do_req(2'b00, 4'd5, 3'd0);
        do_req(2'b00, 4'd5, 3'd3);
        do_req(2'b00, 4'd5, 3'd6);
        do_req(2'b01, 4'd5, 3'd3);
        expect_reply("R10", 3'd3, 8'h41);
        do_req(2'b00, 4'd5, 3'd0);
        expect_fetch("R5", 3'd3);
        do_ack();
        expect_reply("R5", 3'd0, 8'h00);
    endtask

    task automatic t_write_excl();
        do_req(2'b01, 4'd6, 3'd1);
        do_req(2'b01, 4'd6, 3'd5);
        expect_fetch("R8", 3'd1);
        do_ack();
        expect_reply("R8", 3'd5, 8'h00);
        do_req(2'b00, 4'd6, 3'd2);
        expect_fetch("R8", 3'd5);
        do_ack();
    endtask

    task automatic t_wback();
        do_req(2'b01, 4'd7, 3'd3);
        do_req(2'b10, 4'd7, 3'd3);
        expect_silent("R7");
        do_req(2'b00, 4'd7, 3'd4);
        expect_reply("R7", 3'd4, 8'h00);
        do_req(2'b01, 4'd7, 3'd6);
        expect_reply("R7", 3'd6, 8'h10);
    endtask

    task automatic t_ignored();
        do_req(2'b00, 4'd8, 3'd2);
        do_req(2'b10, 4'd8, 3'd2);
        expect_silent("R11");
        do_req(2'b11, 4'd8, 3'd4);
        expect_silent("R11");
        do_req(2'b01, 4'd8, 3'd0);
        expect_reply("R11", 3'd0, 8'h04);
        do_req(2'b01, 4'd9, 3'd1);
        do_req(2'b10, 4'd9, 3'd4);
        expect_silent("R11");
        do_req(2'b00, 4'd9, 3'd5);
        expect_fetch("R11", 3'd1);
        do_ack();
    endtask

    task automatic t_indep();
        do_req(2'b01, 4'd10, 3'd7);
        chk(c_blk == 4'd10, "R12", "msg_block", c_blk, 10);
        do_req(2'b00, 4'd11, 3'd2);
        expect_reply("R12", 3'd2, 8'h00);
        chk(c_blk == 4'd11, "R12", "msg_block", c_blk, 11);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_read_uncached();
        t_read_shared();
        t_write_uncached();
        t_read_excl();
        t_write_shared();
        t_write_excl();
        t_wback();
        t_ignored();
        t_indep();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule